// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit sits beside the register bank of a byte-wide serial port. It holds the interrupt enable register and watches four groups of status inputs: the receive error bits, the received-data-ready bit, the transmit holding-empty bit and the modem change bits. On every clock it picks the one enabled source with the highest priority. It registers the identification code for that source and drives an active-high interrupt request line.

The transmit-empty source needs more than the holding-empty level. It also needs a pending flag that this unit keeps itself. The flag is set when a byte leaves the holding register for the shift register. It is cleared when software writes a new byte or reads the identification register. The register bank and the modem status logic clear the other causes, so this unit only reads their levels.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and after it is released, with no stimulus, `iir_q` reads 0x01, `irq` is 0 and `ier_q` reads 0x00.
- R2: A write on `ier_we` stores `ier_wdata[3:0]`, and `ier_q` shows it one clock later with bits 7..4 reading 0. Enable bit 0 is received data, bit 1 is transmit empty, bit 2 is line status and bit 3 is modem status.
- R3: If enable bit 2 is set and any bit of `lsr_err` is 1 (bit 0 overrun, 1 parity, 2 framing, 3 break), the code is 0x06.
- R4: If enable bit 0 is set, `rx_ready` is 1 and no line status source is active, the code is 0x04.
- R5: The transmit-empty source gives code 0x02 only when enable bit 1 is set, `thr_empty` is 1 and the pending flag is 1. It also needs both higher sources to be inactive.
- R6: If enable bit 3 is set, any bit of `msr_delta` is 1 and no higher source is active, the code is 0x00.
- R7: The priority order, highest first, is line status, received data, transmit empty, then modem status. Only the highest active source is reported.
- R8: When no enabled source is active, the code is 0x01 and `irq` is 0. Otherwise `irq` is 1.
- R9: The pending flag is set by `shift_load` and cleared by `thr_write` or `iir_read`. When a set and a clear arrive in the same cycle, the set wins.
- R10: `iir_q` and `irq` are registered. They show the enable bits, pending flag and status inputs as they stood at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_q | output | 8 | Enable register read value, upper bits zero |
| lsr_err | input | 4 | Receive error bits: overrun, parity, framing, break |
| rx_ready | input | 1 | Received data ready |
| thr_empty | input | 1 | Transmit holding register empty |
| msr_delta | input | 4 | Modem status change bits |
| shift_load | input | 1 | A byte moved from holding register to shifter |
| thr_write | input | 1 | Software wrote the holding register |
| iir_read | input | 1 | Software read the identification register |
| iir_q | output | 8 | Interrupt identification code |
| irq | output | 1 | Interrupt request, active high |

## Verification
The main sweep covers all 32768 combinations of the four enable bits, the four error bits, data ready, holding-empty, pending state and the four modem change bits. This shows that every source is masked by its own enable bit and by nothing else. It also shows that each higher source hides every lower one, and that any single error bit or change bit is enough to trigger its source. Directed sequences check what the sweep cannot: the reset state, that the upper enable bits are dropped, that the set wins when it collides with a clear of the pending flag, that a read of the identification register alone clears the flag, and the one-cycle latency from a status change to the code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Number of interrupt sources, in priority order
  localparam int unsigned SRC_N = 4;
  localparam int unsigned SRC_IDX_W = $clog2(SRC_N);
  localparam int unsigned REG_W = 8;

  // Priority index (0 = highest)
  typedef enum logic [SRC_IDX_W-1:0] {
    PRI_LINE    = 2'd0,
    PRI_RXDATA  = 2'd1,
    PRI_TXEMPTY = 2'd2,
    PRI_MODEM   = 2'd3
  } prio_e;

  // Enable register bit positions
  localparam int unsigned EN_RXDATA  = 0;
  localparam int unsigned EN_TXEMPTY = 1;
  localparam int unsigned EN_LINE    = 2;
  localparam int unsigned EN_MODEM   = 3;

  localparam logic [REG_W-1:0] CODE_IDLE = 8'h01;

  // Identification code for a granted priority index
  function automatic logic [REG_W-1:0] prio_code(input logic [SRC_IDX_W-1:0] idx);
    logic [REG_W-1:0] c;
    case (idx)
      PRI_LINE:    c = 8'h06;
      PRI_RXDATA:  c = 8'h04;
      PRI_TXEMPTY: c = 8'h02;
      default:     c = 8'h00;
    endcase
    return c;
  endfunction

  // Reorder enable bits from register layout to priority layout
  function automatic logic [SRC_N-1:0] en_to_prio(input logic [SRC_N-1:0] en);
    logic [SRC_N-1:0] p;
    p[PRI_LINE]    = en[EN_LINE];
    p[PRI_RXDATA]  = en[EN_RXDATA];
    p[PRI_TXEMPTY] = en[EN_TXEMPTY];
    p[PRI_MODEM]   = en[EN_MODEM];
    return p;
  endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned USED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [USED_W-1:0] en,
  output logic [REG_W-1:0]  rdata
);
  localparam int unsigned PAD_W = REG_W - USED_W;

  logic [USED_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= wdata[USED_W-1:0];
  end

  assign en    = en_q;
  assign rdata = {{PAD_W{1'b0}}, en_q};
endmodule

// File: rtl/uart_irq_thre_pend.sv
module uart_irq_thre_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic wr_evt,
  input  logic rd_evt,
  output logic set_evt,
  output logic clr_evt,
  output logic pend
);
  logic pend_q;

  assign set_evt = load_evt;
  assign clr_evt = (wr_evt | rd_evt) & ~load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  assign pend = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | req[i-1];
  end

  for (genvar i = 0; i < N; i++) begin : g_grant
    assign grant[i] = req[i] & ~blocked[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  output logic [7:0] ier_q,
  input  logic [3:0] lsr_err,
  input  logic       rx_ready,
  input  logic       thr_empty,
  input  logic [3:0] msr_delta,
  input  logic       shift_load,
  input  logic       thr_write,
  input  logic       iir_read,
  output logic [7:0] iir_q,
  output logic       irq
);
  logic [SRC_N-1:0]     ier_en;
  logic [SRC_N-1:0]     raw_src;
  logic [SRC_N-1:0]     req;
  logic [SRC_N-1:0]     grant;
  logic [SRC_IDX_W-1:0] win_idx;
  logic                 any_req;
  logic                 thre_pend;
  logic                 pend_set;
  logic                 pend_clr;
  logic [REG_W-1:0]     iir_r;
  logic                 irq_r;

  uart_irq_enable #(.REG_W(REG_W), .USED_W(SRC_N)) u_en (
    .clk(clk), .rst_n(rst_n), .we(ier_we), .wdata(ier_wdata),
    .en(ier_en), .rdata(ier_q)
  );

  uart_irq_thre_pend u_pend (
    .clk(clk), .rst_n(rst_n), .load_evt(shift_load), .wr_evt(thr_write),
    .rd_evt(iir_read), .set_evt(pend_set), .clr_evt(pend_clr), .pend(thre_pend)
  );

  // Raw causes in priority order
  always_comb begin
    raw_src              = '0;
    raw_src[PRI_LINE]    = |lsr_err;
    raw_src[PRI_RXDATA]  = rx_ready;
    raw_src[PRI_TXEMPTY] = thr_empty & thre_pend;
    raw_src[PRI_MODEM]   = |msr_delta;
  end

  assign req = raw_src & en_to_prio(ier_en);

  uart_irq_prio #(.N(SRC_N)) u_prio (
    .req(req), .grant(grant), .idx(win_idx), .any(any_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_r <= CODE_IDLE;
      irq_r <= 1'b0;
    end else begin
      iir_r <= any_req ? prio_code(win_idx) : CODE_IDLE;
      irq_r <= |grant;
    end
  end

  assign iir_q = iir_r;
  assign irq   = irq_r;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_we,
  input logic [7:0] ier_wdata,
  input logic [7:0] ier_q,
  input logic [3:0] lsr_err,
  input logic       rx_ready,
  input logic [3:0] msr_delta,
  input logic       shift_load,
  input logic       thr_write,
  input logic       iir_read,
  input logic       pend,
  input logic [7:0] iir_q,
  input logic       irq
);
  assert_ier_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ier_q == {4'b0000, $past(ier_wdata[3:0])});

  assert_line_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|lsr_err)) |=> iir_q == 8'h06);

  assert_rxdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[0] && rx_ready && !(ier_q[2] && (|lsr_err))) |=> iir_q == 8'h04);

  assert_thre_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> iir_q != 8'h02);

  assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_q != 8'h01));

  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_load |=> pend);

  assert_pend_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_write || iir_read) && !shift_load) |=> !pend);

  assert_modem_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_q[3] || msr_delta == 4'b0) |=> iir_q != 8'h00);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
  .ier_q(ier_q), .lsr_err(lsr_err), .rx_ready(rx_ready),
  .msr_delta(msr_delta), .shift_load(shift_load), .thr_write(thr_write),
  .iir_read(iir_read), .pend(thre_pend), .iir_q(iir_q), .irq(irq)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_we = 1'b0;
  logic [7:0] ier_wdata = 8'h00;
  logic [7:0] ier_q;
  logic [3:0] lsr_err = 4'h0;
  logic       rx_ready = 1'b0;
  logic       thr_empty = 1'b0;
  logic [3:0] msr_delta = 4'h0;
  logic       shift_load = 1'b0;
  logic       thr_write = 1'b0;
  logic       iir_read = 1'b0;
  logic [7:0] iir_q;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .ier_q(ier_q), .lsr_err(lsr_err), .rx_ready(rx_ready),
    .thr_empty(thr_empty), .msr_delta(msr_delta), .shift_load(shift_load),
    .thr_write(thr_write), .iir_read(iir_read), .iir_q(iir_q), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Expected code, written as a cascade over the register layout
  function automatic logic [7:0] model(input logic [3:0] en, input logic [3:0] err,
                                       input logic dr, input logic te, input logic p,
                                       input logic [3:0] dl);
    if (en[2] && err != 0) return 8'h06;
    if (en[0] && dr) return 8'h04;
    if (en[1] && te && p) return 8'h02;
    if (en[3] && dl != 0) return 8'h00;
    return 8'h01;
  endfunction

  function automatic string req_of(input logic [7:0] code);
    case (code)
      8'h06: return "R3/R7";
      8'h04: return "R4/R7";
      8'h02: return "R5/R7";
      8'h00: return "R6/R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", iir_q, 8'h01);
    check("R1", {7'b0, irq}, 8'h00);
    check("R1", ier_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", iir_q, 8'h01);

    // R2: upper enable bits are dropped
    ier_we = 1'b1; ier_wdata = 8'hFF;
    @(negedge clk);
    ier_we = 1'b0;
    check("R2", ier_q, 8'h0F);
    ier_we = 1'b1; ier_wdata = 8'hA2;
    @(negedge clk);
    ier_we = 1'b0;
    check("R2", ier_q, 8'h02);

    // R9: set wins over a clear in the same cycle
    thr_empty = 1'b1;
    shift_load = 1'b1; iir_read = 1'b1;
    @(negedge clk);
    shift_load = 1'b0; iir_read = 1'b0;
    @(negedge clk);
    check("R9", iir_q, 8'h02);
    check("R8", {7'b0, irq}, 8'h01);
    // R9: identification read alone clears pending
    iir_read = 1'b1;
    @(negedge clk);
    iir_read = 1'b0;
    @(negedge clk);
    check("R9", iir_q, 8'h01);
    // R9: holding write alone clears pending
    shift_load = 1'b1;
    @(negedge clk);
    shift_load = 1'b0;
    thr_write = 1'b1;
    @(negedge clk);
    thr_write = 1'b0;
    @(negedge clk);
    check("R9", iir_q, 8'h01);

    // R10: one-cycle latency from a status change
    ier_we = 1'b1; ier_wdata = 8'h01;
    @(negedge clk);
    ier_we = 1'b0;
    @(negedge clk);
    rx_ready = 1'b1;
    #1;
    check("R10", iir_q, 8'h01);
    @(negedge clk);
    check("R10", iir_q, 8'h04);
    rx_ready = 1'b0;
    @(negedge clk);
    check("R10", iir_q, 8'h01);

    // Exhaustive sweep over all sources, enables and pending state
    for (int v = 0; v < 32768; v++) begin
      logic [14:0] b;
      logic [7:0] exp;
      b = 15'(v);
      ier_we = 1'b1;
      ier_wdata = {b[7:4] ^ b[13:10], b[3:0]};
      lsr_err = b[7:4];
      rx_ready = b[8];
      thr_empty = b[9];
      shift_load = b[10];
      thr_write = ~b[10];
      msr_delta = b[14:11];
      @(negedge clk);
      ier_we = 1'b0; shift_load = 1'b0; thr_write = 1'b0;
      @(negedge clk);
      exp = model(b[3:0], b[7:4], b[8], b[9], b[10], b[14:11]);
      check(req_of(exp), iir_q, exp);
      check("R8", {7'b0, irq}, {7'b0, exp != 8'h01});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule